// File: doc/BRIEF.md
# Dual-Access Zero-Page I/O Register File

This block is a small register memory placed in the lowest page of a 10-bit address space, where it serves as the machine's I/O area. It holds 16 words of 10 bits. Two independent ports reach it. The processor port decodes a full bus address, and the block answers only when the upper address bits are all zero. The device port lets a peripheral reach any word by its 4-bit index, with no address decode.

Storage is set-only. A write can only turn bits on, so software clears a word before it writes new data into it. Each word has its own clear path. Both ports offer the same three commands: clear, write and read. Each command has its own strobe. Reads return through a registered valid/data pair one cycle after the strobe. The read outputs have no ready input and cannot be stalled, so a consumer must take the data in the cycle in which valid is high.

The only back-pressure is on the processor side. When both ports touch the same word in the same cycle, the device port wins. The block then raises the busy output in that same cycle and drops the processor request, which must be presented again. The device port is never held off.

Top module: `zp_io_regfile`

## Requirements
- R1: After reset every word reads as zero from either port.
- R2: A processor write ORs bus_wdata into the addressed word, so 1 bits that were already stored stay set.
- R3: A processor clear sets the addressed word to zero and leaves every other word unchanged.
- R4: When clear and write are strobed together for one word, the word afterwards holds exactly the write data.
- R5: A processor read raises bus_rvalid one cycle after the strobe. bus_rdata then carries the word as it stood before that clock edge. A write in the same cycle therefore shows only on a later read, and a read leaves the word unchanged.
- R6: The processor port is selected only when bus_addr[9:4] is all zero, and bus_addr[3:0] then picks the word. An unselected access changes no word, gives no bus_rvalid and never raises bus_busy.
- R7: The device port offers the same clear, write (OR) and read commands at the index dev_idx. dev_rvalid and dev_rdata follow one cycle after dev_rd.
- R8: If a selected processor command and any device command name the same word in the same cycle, bus_busy is high in that cycle. The device command takes effect, and the processor command has no effect and gives no bus_rvalid.
- R9: Commands on the two ports that name different words both take effect in the same cycle, and bus_busy stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 10 | Processor address |
| bus_wdata | input | 10 | Processor write data |
| bus_clr | input | 1 | Processor clear strobe |
| bus_wr | input | 1 | Processor write-select strobe (OR into word) |
| bus_rd | input | 1 | Processor read strobe |
| bus_busy | output | 1 | Processor command refused this cycle, resend |
| bus_rdata | output | 10 | Processor read data |
| bus_rvalid | output | 1 | bus_rdata valid |
| dev_idx | input | 4 | Device word index |
| dev_wdata | input | 10 | Device write data |
| dev_clr | input | 1 | Device clear strobe |
| dev_wr | input | 1 | Device write strobe (OR into word) |
| dev_rd | input | 1 | Device read strobe |
| dev_rdata | output | 10 | Device read data |
| dev_rvalid | output | 1 | dev_rdata valid |

## Verification
bus_busy is combinational, so the bench checks it a short time after it drives a command, in the same cycle. Stored words change at the next rising edge. Read valid and data are due exactly one edge after the strobe, and the bench compares them at the following falling edge. A behavioural model of the 16 words captures its read results before it applies that edge's clears and writes. It compares the outputs in every cycle, so a read issued in the same cycle as a write must return the old value.

// File: rtl/zp_io_pkg.sv
package zp_io_pkg;
  typedef struct packed {
    logic clr;
    logic wr;
    logic rd;
  } zp_cmd_t;

  function automatic logic cmd_any(input zp_cmd_t c);
    return c.clr | c.wr | c.rd;
  endfunction
endpackage

// File: rtl/zp_bus_decode.sv
module zp_bus_decode #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel,
  output logic [IDX_W-1:0]  idx
);
  // Zero page: every bit above the word index must be low.
  assign sel = ~|addr[ADDR_W-1:IDX_W];
  assign idx = addr[IDX_W-1:0];
endmodule

// File: rtl/zp_port_arbiter.sv
module zp_port_arbiter
  import zp_io_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  zp_cmd_t          bus_cmd,
  input  logic             bus_sel,
  input  logic [IDX_W-1:0] bus_idx,
  input  zp_cmd_t          dev_cmd,
  input  logic [IDX_W-1:0] dev_idx,
  output zp_cmd_t          bus_grant,
  output logic             busy
);
  logic bus_req;
  logic clash;

  assign bus_req = bus_sel & cmd_any(bus_cmd);
  // The device path has priority on a shared word.
  assign clash   = bus_req & cmd_any(dev_cmd) & (bus_idx == dev_idx);
  assign busy    = clash;

  always_comb begin
    bus_grant = '0;
    if (bus_req && !clash) begin
      bus_grant = bus_cmd;
    end
  end
endmodule

// File: rtl/zp_word_cell.sv
module zp_word_cell #(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [DATA_W-1:0] set_mask,
  output logic [DATA_W-1:0] q
);
  // One storage flop per bit; a bit can only be raised by set_mask and
  // dropped by the word-wide clear. Clear acts before set in a cycle.
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[b] <= 1'b0;
      end else begin
        q[b] <= (q[b] & ~clr) | set_mask[b];
      end
    end
  end
endmodule

// File: rtl/zp_read_port.sv
module zp_read_port #(
  parameter int DATA_W = 10,
  parameter int WORDS  = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] words [WORDS],
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  idx,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  logic [DATA_W-1:0] gated [WORDS];
  logic [DATA_W-1:0] merged;

  // Per-word select gate, then a wired-OR style merge.
  for (genvar w = 0; w < WORDS; w++) begin : g_gate
    assign gated[w] = words[w] & {DATA_W{idx == IDX_W'(w)}};
  end

  always_comb begin
    merged = '0;
    for (int w = 0; w < WORDS; w++) begin
      merged = merged | gated[w];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= merged;
      end
    end
  end
endmodule

// File: rtl/zp_io_regfile.sv
module zp_io_regfile
  import zp_io_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 10,
  parameter int WORDS  = 16,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_clr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic              bus_busy,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  input  logic [IDX_W-1:0]  dev_idx,
  input  logic [DATA_W-1:0] dev_wdata,
  input  logic              dev_clr,
  input  logic              dev_wr,
  input  logic              dev_rd,
  output logic [DATA_W-1:0] dev_rdata,
  output logic              dev_rvalid
);
  zp_cmd_t           bus_cmd;
  zp_cmd_t           dev_cmd;
  zp_cmd_t           bus_grant;
  logic              bus_sel;
  logic [IDX_W-1:0]  bus_idx;
  logic [DATA_W-1:0] word_q [WORDS];

  assign bus_cmd = '{clr: bus_clr, wr: bus_wr, rd: bus_rd};
  assign dev_cmd = '{clr: dev_clr, wr: dev_wr, rd: dev_rd};

  zp_bus_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_decode (
    .addr (bus_addr),
    .sel  (bus_sel),
    .idx  (bus_idx)
  );

  zp_port_arbiter #(.IDX_W(IDX_W)) u_arb (
    .bus_cmd   (bus_cmd),
    .bus_sel   (bus_sel),
    .bus_idx   (bus_idx),
    .dev_cmd   (dev_cmd),
    .dev_idx   (dev_idx),
    .bus_grant (bus_grant),
    .busy      (bus_busy)
  );

  // Per-word clear and set paths; the arbiter guarantees that the two
  // ports never both act on one word in a cycle.
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic              hit_bus;
    logic              hit_dev;
    logic              w_clr;
    logic [DATA_W-1:0] w_set;

    assign hit_bus = (bus_idx == IDX_W'(w));
    assign hit_dev = (dev_idx == IDX_W'(w));
    assign w_clr   = (hit_bus & bus_grant.clr) | (hit_dev & dev_cmd.clr);
    assign w_set   = (bus_wdata & {DATA_W{hit_bus & bus_grant.wr}})
                   | (dev_wdata & {DATA_W{hit_dev & dev_cmd.wr}});

    zp_word_cell #(.DATA_W(DATA_W)) u_cell (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (w_clr),
      .set_mask (w_set),
      .q        (word_q[w])
    );
  end

  zp_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_bus_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .words  (word_q),
    .rd_en  (bus_grant.rd),
    .idx    (bus_idx),
    .rdata  (bus_rdata),
    .rvalid (bus_rvalid)
  );

  zp_read_port #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_dev_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .words  (word_q),
    .rd_en  (dev_cmd.rd),
    .idx    (dev_idx),
    .rdata  (dev_rdata),
    .rvalid (dev_rvalid)
  );
endmodule

// File: rtl/zp_io_regfile_chk.sv
module zp_io_regfile_chk #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_clr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_busy,
  input logic              bus_rvalid,
  input logic              dev_clr,
  input logic              dev_wr,
  input logic              dev_rd,
  input logic              dev_rvalid
);
  logic sel;
  assign sel = (bus_addr[ADDR_W-1:IDX_W] == '0);

  // R5
  bus_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && sel && !bus_busy) |=> bus_rvalid);

  // R6
  bus_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && sel && !bus_busy) |=> !bus_rvalid);

  // R6
  busy_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (sel && (bus_clr || bus_wr || bus_rd)));

  // R8
  busy_dev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_busy |-> (dev_clr || dev_wr || dev_rd));

  // R7
  dev_rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_rd |=> dev_rvalid);

  // R7
  dev_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rd |=> !dev_rvalid);
endmodule

bind zp_io_regfile zp_io_regfile_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_clr    (bus_clr),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_busy   (bus_busy),
  .bus_rvalid (bus_rvalid),
  .dev_clr    (dev_clr),
  .dev_wr     (dev_wr),
  .dev_rd     (dev_rd),
  .dev_rvalid (dev_rvalid)
);

// File: tb/zp_io_regfile_tb.sv
module zp_io_regfile_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] bus_addr = '0;
  logic [9:0] bus_wdata = '0;
  logic       bus_clr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic       bus_busy;
  logic [9:0] bus_rdata;
  logic       bus_rvalid;
  logic [3:0] dev_idx = '0;
  logic [9:0] dev_wdata = '0;
  logic       dev_clr = 1'b0, dev_wr = 1'b0, dev_rd = 1'b0;
  logic [9:0] dev_rdata;
  logic       dev_rvalid;

  int    total = 0;
  int    bad = 0;
  string cur_req = "R1";

  // reference state
  logic [9:0] mem [16];
  logic       e_brv, e_drv;
  logic [9:0] e_brd, e_drd;

  always #2 clk = ~clk;

  zp_io_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_clr(bus_clr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_busy(bus_busy), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dev_idx(dev_idx), .dev_wdata(dev_wdata),
    .dev_clr(dev_clr), .dev_wr(dev_wr), .dev_rd(dev_rd),
    .dev_rdata(dev_rdata), .dev_rvalid(dev_rvalid)
  );

  function automatic logic m_conflict();
    logic bsel = (bus_addr[9:4] == 6'd0);
    return bsel && (bus_clr || bus_wr || bus_rd) &&
           (dev_clr || dev_wr || dev_rd) && (bus_addr[3:0] == dev_idx);
  endfunction

  // behavioural model: read results first, then device update, then bus
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) mem[i] = '0;
      e_brv <= 1'b0; e_drv <= 1'b0; e_brd <= '0; e_drd <= '0;
    end else begin
      logic bsel;
      logic conf;
      int   bi;
      int   di;
      bsel = (bus_addr[9:4] == 6'd0);
      conf = m_conflict();
      bi = int'(bus_addr[3:0]);
      di = int'(dev_idx);
      e_brv <= bsel && bus_rd && !conf;
      if (bsel && bus_rd && !conf) e_brd <= mem[bi];
      e_drv <= dev_rd;
      if (dev_rd) e_drd <= mem[di];
      if (dev_clr) mem[di] = '0;
      if (dev_wr)  mem[di] = mem[di] | dev_wdata;
      if (bsel && !conf) begin
        if (bus_clr) mem[bi] = '0;
        if (bus_wr)  mem[bi] = mem[bi] | bus_wdata;
      end
    end
  end

  task automatic check(input string what, input logic [9:0] got, input logic [9:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", cur_req, what, got, exp);
    end
  endtask

  // inputs are already set at a falling edge; check busy, then results
  task automatic tick();
    #1;
    check("bus_busy", {9'd0, bus_busy}, {9'd0, m_conflict()});
    @(negedge clk);
    check("bus_rvalid", {9'd0, bus_rvalid}, {9'd0, e_brv});
    if (e_brv) check("bus_rdata", bus_rdata, e_brd);
    check("dev_rvalid", {9'd0, dev_rvalid}, {9'd0, e_drv});
    if (e_drv) check("dev_rdata", dev_rdata, e_drd);
    bus_clr = 0; bus_wr = 0; bus_rd = 0;
    dev_clr = 0; dev_wr = 0; dev_rd = 0;
  endtask

  task automatic bus_op(input logic c, input logic w, input logic r,
                        input logic [9:0] a, input logic [9:0] d);
    bus_clr = c; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    tick();
  endtask

  task automatic idle();
    tick();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: every word reads zero after reset
    cur_req = "R1";
    check("rst bus_rvalid", {9'd0, bus_rvalid}, 10'd0);
    for (int i = 0; i < 16; i++) bus_op(0, 0, 1, 10'(i), '0);
    idle();
    // R2: OR semantics
    cur_req = "R2";
    bus_op(0, 1, 0, 10'd3, 10'h155);
    bus_op(0, 0, 1, 10'd3, '0);
    bus_op(0, 1, 0, 10'd3, 10'h0AA);
    bus_op(0, 0, 1, 10'd3, '0);
    idle();
    check("R2 word3", bus_rdata, 10'h155 | 10'h0AA);
    // R3: clear only the addressed word
    cur_req = "R3";
    bus_op(0, 1, 0, 10'd4, 10'h00F);
    bus_op(1, 0, 0, 10'd3, '0);
    bus_op(0, 0, 1, 10'd3, '0);
    bus_op(0, 0, 1, 10'd4, '0);
    idle();
    // R4: clear and write together
    cur_req = "R4";
    bus_op(0, 1, 0, 10'd5, 10'h3F0);
    bus_op(1, 1, 0, 10'd5, 10'h00C);
    bus_op(0, 0, 1, 10'd5, '0);
    idle();
    // R5: read with write in same cycle returns old value, reads are stable
    cur_req = "R5";
    bus_op(0, 1, 1, 10'd4, 10'h200);
    bus_op(0, 0, 1, 10'd4, '0);
    bus_op(0, 0, 1, 10'd4, '0);
    idle();
    // R6: unselected addresses alias nothing and never go busy
    cur_req = "R6";
    dev_idx = 4'd3; dev_rd = 1;
    bus_op(0, 1, 1, 10'h013, 10'h3FF);
    bus_op(1, 0, 0, 10'h204, '0);
    bus_op(0, 0, 1, 10'd3, '0);
    bus_op(0, 0, 1, 10'd4, '0);
    idle();
    // R7: device port commands
    cur_req = "R7";
    dev_idx = 4'd9; dev_wr = 1; dev_wdata = 10'h111; tick();
    dev_idx = 4'd9; dev_wr = 1; dev_wdata = 10'h222; tick();
    dev_idx = 4'd9; dev_rd = 1; tick();
    dev_idx = 4'd9; dev_clr = 1; dev_wr = 1; dev_wdata = 10'h005; tick();
    dev_idx = 4'd9; dev_rd = 1; tick();
    idle();
    // R8: same word, device wins
    cur_req = "R8";
    dev_idx = 4'd6; dev_wr = 1; dev_wdata = 10'h018;
    bus_op(0, 1, 1, 10'd6, 10'h300);
    dev_idx = 4'd6; dev_rd = 1;
    bus_op(1, 0, 0, 10'd6, '0);
    bus_op(0, 0, 1, 10'd6, '0);
    idle();
    // R9: different words proceed together
    cur_req = "R9";
    dev_idx = 4'd7; dev_wr = 1; dev_wdata = 10'h0C3;
    bus_op(0, 1, 0, 10'd8, 10'h1E1);
    dev_idx = 4'd8; dev_rd = 1;
    bus_op(0, 0, 1, 10'd7, '0);
    idle();
    // mixed traffic against the model
    for (int n = 0; n < 600; n++) begin
      logic [3:0] bi;
      bi = 4'($urandom % 16);
      cur_req = (n % 2 == 0) ? "R2" : "R9";
      bus_addr  = ($urandom % 8 == 0) ? 10'($urandom) : {6'd0, bi};
      bus_wdata = 10'($urandom);
      bus_clr = ($urandom % 5 == 0);
      bus_wr  = ($urandom % 2 == 0);
      bus_rd  = ($urandom % 2 == 0);
      dev_idx   = ($urandom % 3 == 0) ? bi : 4'($urandom);
      dev_wdata = 10'($urandom);
      dev_clr = ($urandom % 6 == 0);
      dev_wr  = ($urandom % 3 == 0);
      dev_rd  = ($urandom % 2 == 0);
      tick();
    end
    idle();
    idle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule